// File: doc/BRIEF.md
# Time-Slotted Round-Robin Bus Arbiter

This arbiter hands out a shared cluster data bus to a fixed set of requesters, the leaf processors of a cluster plus its root processors. Time is cut into slots of one bus cycle each. A slot pointer walks through the participating requesters in ascending index order, wrapping at the top. A participant owns its slot whether or not it has anything to send, so the wait any requester sees is bounded and the same for all.

Each bus transfer is split in two. The address goes out in one of the requester's slots, and the matching data phase follows in that requester's next slot. In standard use an element therefore costs two full rotations. A requester that keeps its chain input high turns each later slot into a combined slot: it carries the data of the previous element and the address of the next one, so after the first element each element costs a single rotation. A requester with no need for the bus raises its opt-out input and drops out of the rotation, which shortens the rotation for everyone else.

Each lane runs a two-state machine. Its states are IDLE (no transfer open) and PENDING (an address has been issued and its data phase is owed). The transitions are START (IDLE to PENDING: the lane's slot arrives with a request), CONTINUE (PENDING to PENDING: the slot arrives with request and chain both high), CLOSE (PENDING to IDLE: the slot arrives without a chained request) and HOLD (no change outside the lane's own slot).

Top module: `slot_bus_arbiter`

## Requirements
- R1: While reset is held and after it is released with no request, grant is all-zero and both phase flags are low; the first slot after reset belongs to requester 0.
- R2: The slot pointer moves once per clock to the next participating requester in ascending index order with wrap-around; a participant uses up its slot even when it does not request.
- R3: Grant is a registered vector that is one-hot when a slot is used and all-zero otherwise, and a phase flag is high exactly when grant is non-zero; it reflects the slot decided at the previous clock edge.
- R4: An idle requester that requests in its slot is granted with addr_phase_o=1 and data_phase_o=0, and its data phase (data_phase_o=1, addr_phase_o=0) follows in its next slot, so a held non-chained request yields one element every two of its slots.
- R5: A data phase owed to a requester is granted in its next slot even if the requester has withdrawn its request.
- R6: A requester with a data phase owed that has both request and chain high in its slot is granted with both phase flags high, so each chained element after the first costs one rotation.
- R7: When chain is low in a slot where a data phase is owed, only the data phase is granted; the requester's next request then starts again with an address-only slot.
- R8: A requester with opt-out high and no data phase owed takes no slot, and its request is ignored.
- R9: Opt-out raised while a data phase is owed takes effect only after that data phase has been granted.
- R10: When every requester has opted out and none owes a data phase, no grant is given and the pointer stays where it is.
- R11: A requester that clears its opt-out is eligible from the next slot boundary: with the pointer parked on an opted-out requester, the slot after the clearing edge goes to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one slot per cycle |
| rst_n | input | 1 | Active-low reset |
| req_i | input | NREQ | Per-requester bus request |
| chain_i | input | NREQ | Per-requester chained-vector request |
| optout_i | input | NREQ | Per-requester leave-rotation request |
| grant_o | output | NREQ | Registered grant, one-hot or zero |
| addr_phase_o | output | 1 | Granted slot carries an address phase |
| data_phase_o | output | 1 | Granted slot carries a data phase |

## Verification
The bench builds the arbiter with three leaf and one root requester, so a full rotation is four cycles. That short period puts wrap-around, a two-element rotation with two requesters opted out, the all-opted-out idle case and the rejoin after it within a few dozen cycles each. It also keeps the exact slot of every address, data and combined phase easy to predict by hand.

// File: rtl/sba_pkg.sv
package sba_pkg;

    typedef enum logic [0:0] {
        LANE_IDLE    = 1'b0,
        LANE_PENDING = 1'b1
    } lane_state_e;

endpackage

// File: rtl/sba_slot_rotor.sv
module sba_slot_rotor #(
    parameter  int NREQ  = 4,
    localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  active_i,
    output logic [IDX_W-1:0] slot_idx_o,
    output logic             slot_valid_o
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_d;
    logic             found;

    // Search strictly after the current owner, wrapping once.
    always_comb begin
        ptr_d = ptr_q;
        found = 1'b0;
        for (int k = 1; k <= NREQ; k++) begin
            logic [IDX_W:0] cand;
            cand = {1'b0, ptr_q} + (IDX_W+1)'(k);
            if (cand >= (IDX_W+1)'(NREQ)) begin
                cand = cand - (IDX_W+1)'(NREQ);
            end
            if (!found && active_i[cand[IDX_W-1:0]]) begin
                ptr_d = cand[IDX_W-1:0];
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign slot_idx_o   = ptr_q;
    assign slot_valid_o = active_i[ptr_q];

endmodule

// File: rtl/sba_lane_fsm.sv
module sba_lane_fsm
    import sba_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slot_hit_i,
    input  logic req_i,
    input  logic chain_i,
    output logic pending_o,
    output logic issue_addr_o,
    output logic issue_data_o
);

    lane_state_e state_q;
    lane_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        issue_addr_o = 1'b0;
        issue_data_o = 1'b0;
        unique case (state_q)
            LANE_IDLE: begin
                if (slot_hit_i && req_i) begin
                    issue_addr_o = 1'b1;
                    state_d      = LANE_PENDING;
                end
            end
            LANE_PENDING: begin
                if (slot_hit_i) begin
                    issue_data_o = 1'b1;
                    if (req_i && chain_i) begin
                        issue_addr_o = 1'b1;
                        state_d      = LANE_PENDING;
                    end else begin
                        state_d      = LANE_IDLE;
                    end
                end
            end
            default: state_d = LANE_IDLE;
        endcase
    end

    assign pending_o = (state_q == LANE_PENDING);

endmodule

// File: rtl/sba_grant_reg.sv
module sba_grant_reg #(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] issue_addr_i,
    input  logic [NREQ-1:0] issue_data_i,
    output logic [NREQ-1:0] grant_o,
    output logic            addr_phase_o,
    output logic            data_phase_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_o      <= '0;
            addr_phase_o <= 1'b0;
            data_phase_o <= 1'b0;
        end else begin
            grant_o      <= issue_addr_i | issue_data_i;
            addr_phase_o <= |issue_addr_i;
            data_phase_o <= |issue_data_i;
        end
    end

endmodule

// File: rtl/slot_bus_arbiter.sv
module slot_bus_arbiter #(
    parameter  int NUM_LEAF = 8,
    parameter  int NUM_ROOT = 4,
    localparam int NREQ     = NUM_LEAF + NUM_ROOT,
    localparam int IDX_W    = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_i,
    input  logic [NREQ-1:0] chain_i,
    input  logic [NREQ-1:0] optout_i,
    output logic [NREQ-1:0] grant_o,
    output logic            addr_phase_o,
    output logic            data_phase_o
);

    logic [NREQ-1:0]  pending;
    logic [NREQ-1:0]  active;
    logic [NREQ-1:0]  slot_hit;
    logic [NREQ-1:0]  issue_addr;
    logic [NREQ-1:0]  issue_data;
    logic [IDX_W-1:0] slot_idx;
    logic             slot_valid;

    // A lane owing a data phase stays in the rotation despite opt-out.
    assign active = ~optout_i | pending;

    sba_slot_rotor #(.NREQ(NREQ)) u_rotor (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (active),
        .slot_idx_o   (slot_idx),
        .slot_valid_o (slot_valid)
    );

    for (genvar i = 0; i < NREQ; i++) begin : g_lane
        assign slot_hit[i] = slot_valid && (slot_idx == IDX_W'(i));

        sba_lane_fsm u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .slot_hit_i   (slot_hit[i]),
            .req_i        (req_i[i]),
            .chain_i      (chain_i[i]),
            .pending_o    (pending[i]),
            .issue_addr_o (issue_addr[i]),
            .issue_data_o (issue_data[i])
        );
    end

    sba_grant_reg #(.NREQ(NREQ)) u_grant (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_addr_i (issue_addr),
        .issue_data_i (issue_data),
        .grant_o      (grant_o),
        .addr_phase_o (addr_phase_o),
        .data_phase_o (data_phase_o)
    );

endmodule

// File: rtl/slot_bus_arbiter_chk.sv
module slot_bus_arbiter_chk #(
    parameter int NREQ = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] optout,
    input logic [NREQ-1:0] pending,
    input logic [NREQ-1:0] grant,
    input logic            addr_phase,
    input logic            data_phase
);

    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_has_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (addr_phase || data_phase));

    p_phase_has_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase || data_phase) |-> (grant != '0));

    p_silent_all_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((&optout) && (pending == '0)) |=> (grant == '0));

    for (genvar i = 0; i < NREQ; i++) begin : g_lane_chk
        p_skip_opted_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (optout[i] && !pending[i]) |=> !grant[i]);

        p_addr_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && addr_phase) |-> pending[i]);

        p_data_only_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && data_phase && !addr_phase) |-> !pending[i]);
    end

endmodule

bind slot_bus_arbiter slot_bus_arbiter_chk #(.NREQ(NREQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .optout     (optout_i),
    .pending    (pending),
    .grant      (grant_o),
    .addr_phase (addr_phase_o),
    .data_phase (data_phase_o)
);

// File: tb/tb_slot_bus_arbiter.sv
module tb_slot_bus_arbiter;

    localparam int NREQ = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] req = '0;
    logic [NREQ-1:0] chain = '0;
    logic [NREQ-1:0] optout = '0;
    logic [NREQ-1:0] grant;
    logic            addr_ph;
    logic            data_ph;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    slot_bus_arbiter #(.NUM_LEAF(3), .NUM_ROOT(1)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .chain_i      (chain),
        .optout_i     (optout),
        .grant_o      (grant),
        .addr_phase_o (addr_ph),
        .data_phase_o (data_ph)
    );

    task automatic expect_out(input string tag, input logic [NREQ-1:0] g,
                              input logic a, input logic d);
        n_checks++;
        if (grant !== g || addr_ph !== a || data_ph !== d) begin
            n_fails++;
            $display("FAIL %s: grant=%b addr=%b data=%b, expected grant=%b addr=%b data=%b",
                     tag, grant, addr_ph, data_ph, g, a, d);
        end
    endtask

    // Advance one clock edge, then sit at the falling edge.
    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Inputs are set by the caller beforehand; release lands on a falling edge.
    task automatic restart();
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        req = '0; chain = '0; optout = '0;
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        expect_out("R1 during reset", 4'b0000, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(4);
        expect_out("R1 idle after release", 4'b0000, 1'b0, 1'b0);
        // First slot goes to requester 0.
        req = 4'b0001;
        restart();
        step(1);
        expect_out("R1 first slot owner", 4'b0001, 1'b1, 1'b0);
    endtask

    task automatic t_standard();
        req = 4'b0100; chain = '0; optout = '0;
        restart();
        step(2);
        expect_out("R2 slots 0,1 unused", 4'b0000, 1'b0, 1'b0);
        step(1);
        expect_out("R4 address slot", 4'b0100, 1'b1, 1'b0);
        step(2);
        expect_out("R2 others' slot", 4'b0000, 1'b0, 1'b0);
        step(2);
        expect_out("R4 data slot", 4'b0100, 1'b0, 1'b1);
        step(4);
        expect_out("R4 second address", 4'b0100, 1'b1, 1'b0);
        step(4);
        expect_out("R4 second data", 4'b0100, 1'b0, 1'b1);
    endtask

    task automatic t_chained();
        req = 4'b0010; chain = 4'b0010; optout = '0;
        restart();
        step(2);
        expect_out("R6 first address", 4'b0010, 1'b1, 1'b0);
        step(1);
        expect_out("R2 gap", 4'b0000, 1'b0, 1'b0);
        step(3);
        expect_out("R6 combined slot", 4'b0010, 1'b1, 1'b1);
        step(4);
        expect_out("R6 combined again", 4'b0010, 1'b1, 1'b1);
        chain = '0;
        step(4);
        expect_out("R7 data only on chain drop", 4'b0010, 1'b0, 1'b1);
        step(4);
        expect_out("R7 restart address only", 4'b0010, 1'b1, 1'b0);
    endtask

    task automatic t_optout();
        req = 4'b1111; chain = '0; optout = 4'b1010;
        restart();
        step(1);
        expect_out("R8 owner 0 addr", 4'b0001, 1'b1, 1'b0);
        step(1);
        expect_out("R8 skip 1 to 2", 4'b0100, 1'b1, 1'b0);
        step(1);
        expect_out("R8 skip 3 to 0", 4'b0001, 1'b0, 1'b1);
        step(1);
        expect_out("R8 two-member rotation", 4'b0100, 1'b0, 1'b1);
    endtask

    task automatic t_all_out();
        req = 4'b1111; chain = '0; optout = 4'b1111;
        restart();
        step(3);
        expect_out("R10 no grant", 4'b0000, 1'b0, 1'b0);
        optout = 4'b0111;
        step(1);
        expect_out("R11 parked slot empty", 4'b0000, 1'b0, 1'b0);
        step(1);
        expect_out("R11 rejoin next slot", 4'b1000, 1'b1, 1'b0);
    endtask

    task automatic t_deferred_out();
        req = 4'b0001; chain = '0; optout = '0;
        restart();
        step(1);
        expect_out("R9 address before opt-out", 4'b0001, 1'b1, 1'b0);
        req = '0; optout = 4'b0001;
        step(4);
        expect_out("R5 R9 owed data granted", 4'b0001, 1'b0, 1'b1);
        req = 4'b0001;
        for (int k = 0; k < 4; k++) begin
            step(1);
            expect_out("R8 request ignored while out", 4'b0000, 1'b0, 1'b0);
        end
    endtask

    initial begin
        t_reset();
        t_standard();
        t_chained();
        t_optout();
        t_all_out();
        t_deferred_out();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule